// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a five-digit decimal result one digit at a time. It drives a one-hot set of positive-going digit-select lines, a 4-bit BCD bus that carries the code of the selected digit, and an active-low strobe. The strobe marks the middle of each digit period, so an external latch or processor can capture the digit. Scanning runs continuously from the conversion clock and always starts with the most significant digit. The most significant digit stays selected for one clock longer than the other digits.

A pulse on `new_result_i` loads a fresh result and its overrange flag. It restarts the scan at the top digit and arms exactly one strobe per digit for the pass that follows. Later passes repeat the scan without strobes.

While the loaded result is overrange, the BCD bus is forced to zero. After the last digit's strobe slot, all select lines go dark until `resume_i` signals the start of the next reference-integrate phase. The scan then runs again from the top. The resulting pattern makes a display blink.

Top module: `bcd_scanner`

## Requirements
- R1: Exactly one of `digit_o` is high while scanning (bit k selects digit k+1, bit 4 is the most significant). The order is bit 4, 3, 2, 1, 0, and the scan then wraps to bit 4 without a gap.
- R2: Bit 4 of `digit_o` stays high for 201 consecutive clocks, and each other bit stays high for 200 clocks.
- R3: `bcd_o` equals `result_i[4k+3:4k]` of the latched result in every cycle that bit k of `digit_o` is high. It changes in the same cycle as the select.
- R4: `bcd_o` is zero in every cycle in which no digit is selected.
- R5: Each strobe lasts exactly one clock-low half, with the strobe high again at the next rising edge. The most significant digit's strobe falls in the low half of the 102nd clock of its select (offset 101 from the select's rising edge). Every other digit's strobe falls at offset 100.
- R6: After each `new_result_i` pulse, `strobe_n_o` pulses exactly five times, once per digit, and later scans produce no strobes.
- R7: A `new_result_i` pulse sampled at a rising edge selects bit 4 from the next cycle, even in the middle of a scan. It restarts the digit timing and re-arms the five strobes.
- R8: While the latched result is flagged overrange, `bcd_o` is zero in every cycle.
- R9: With overrange, every `digit_o` bit is low from the cycle after the least significant digit's strobe slot until `resume_i` is sampled high. Scanning then restarts at bit 4 in the next cycle, and each later pass blanks at the same point with no strobe.
- R10: `resume_i` has no effect on any output while the display is not blanked.
- R11: After reset and before any result, the block scans with bit 4 selected first, keeps `bcd_o` at zero and keeps `strobe_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | 20 | Five BCD digits, least significant in bits 3:0 |
| over_i | input | 1 | Overrange flag captured with the result |
| new_result_i | input | 1 | One-cycle pulse: load result, restart scan, arm strobes |
| resume_i | input | 1 | Start of reference-integrate phase; ends overrange blanking |
| digit_o | output | 5 | One-hot digit selects, bit 4 most significant |
| bcd_o | output | 4 | BCD code of the selected digit |
| strobe_n_o | output | 1 | Active-low half-clock transfer strobe |

## Verification
The assertions watch, in every cycle, that the selects stay one-hot or dark and that the bus is empty when nothing is selected or the result is overrange. They also check that the timer never runs past its digit length, that a blanked display keeps every select low, and that a strobe never spans two clocks. Only the bench scenarios can show the exact 201/200-clock widths and the 101/100 strobe offsets. The same holds for the count of five strobes per result, the restart on a mid-scan result, and the blink cycle that the resume pulse ends.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
    localparam int BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        logic over;   // latched result is out of range
        logic armed;  // strobes still owed for the current result
        logic blank;  // selects held dark until resume
    } scan_flags_t;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int NUM_DIGITS  = 5,
    parameter int DIGIT_CLKS  = 200,
    parameter int FIRST_EXTRA = 1,
    parameter int STROBE_OFS  = 100,
    parameter int IDX_W       = 3,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             centre_o
);
    localparam logic [IDX_W-1:0] TOP      = IDX_W'(NUM_DIGITS - 1);
    localparam logic [CNT_W-1:0] END_TOP  = CNT_W'(DIGIT_CLKS + FIRST_EXTRA - 1);
    localparam logic [CNT_W-1:0] END_REST = CNT_W'(DIGIT_CLKS - 1);
    localparam logic [CNT_W-1:0] MID_TOP  = CNT_W'(STROBE_OFS + FIRST_EXTRA);
    localparam logic [CNT_W-1:0] MID_REST = CNT_W'(STROBE_OFS);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic is_top, at_end;

    always_comb begin
        is_top = (tmr_q.idx == TOP);
        at_end = (tmr_q.cnt == (is_top ? END_TOP : END_REST));
        tmr_d  = tmr_q;
        if (restart_i) begin
            tmr_d.idx = TOP;
            tmr_d.cnt = '0;
        end else if (run_i) begin
            if (at_end) begin
                tmr_d.cnt = '0;
                tmr_d.idx = (tmr_q.idx == '0) ? TOP : tmr_q.idx - 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{idx: TOP, cnt: '0};
        else        tmr_q <= tmr_d;
    end

    assign idx_o    = tmr_q.idx;
    assign centre_o = (tmr_q.cnt == (is_top ? MID_TOP : MID_REST));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= ((tmr_q.idx == TOP) ? END_TOP : END_REST));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.idx <= TOP);

    // R1
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && at_end && tmr_q.idx != '0)
        |=> (tmr_q.idx == $past(tmr_q.idx) - 1'b1) && (tmr_q.cnt == '0));
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic strobe_n_o
);
    logic fall_q;  // captured at the falling edge
    logic rise_q;  // follows fall_q at the next rising edge

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= fall_q;
    end

    // Low only between the falling edge and the following rising edge.
    assign strobe_n_o = ~(fall_q & ~rise_q);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);
endmodule

// File: rtl/digit_mux.sv
module digit_mux
    import bcd_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 5,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_DIGITS*BCD_W-1:0] data_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic                        blank_i,
    input  logic                        zero_i,
    output logic [NUM_DIGITS-1:0]       digit_o,
    output bcd_t                        bcd_o
);
    bcd_t part [NUM_DIGITS];

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_lane
        assign digit_o[k] = !blank_i && (idx_i == IDX_W'(k));
        assign part[k]    = (digit_o[k] && !zero_i) ? data_i[k*BCD_W +: BCD_W] : '0;
    end

    always_comb begin
        bcd_o = '0;
        for (int k = 0; k < NUM_DIGITS; k++) bcd_o = bcd_o | part[k];
    end
endmodule

// File: rtl/bcd_scanner.sv
module bcd_scanner
    import bcd_scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 5,
    parameter int DIGIT_CLKS  = 200,
    parameter int FIRST_EXTRA = 1,
    parameter int STROBE_OFS  = 100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DIGITS*BCD_W-1:0] result_i,
    input  logic                        over_i,
    input  logic                        new_result_i,
    input  logic                        resume_i,
    output logic [NUM_DIGITS-1:0]       digit_o,
    output logic [BCD_W-1:0]            bcd_o,
    output logic                        strobe_n_o
);
    localparam int IDX_W  = $clog2(NUM_DIGITS);
    localparam int CNT_W  = $clog2(DIGIT_CLKS + FIRST_EXTRA);
    localparam int DATA_W = NUM_DIGITS * BCD_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        scan_flags_t       f;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [IDX_W-1:0] idx;
    logic             centre;
    logic             last_slot;
    logic             restart;
    logic             fire;

    assign last_slot = centre && (idx == '0) && !ctrl_q.f.blank;
    assign restart   = new_result_i || (ctrl_q.f.blank && resume_i);
    assign fire      = ctrl_q.f.armed && centre && !ctrl_q.f.blank;

    always_comb begin
        ctrl_d = ctrl_q;
        if (new_result_i) begin
            ctrl_d.data    = result_i;
            ctrl_d.f.over  = over_i;
            ctrl_d.f.armed = 1'b1;
            ctrl_d.f.blank = 1'b0;
        end else begin
            if (last_slot) begin
                ctrl_d.f.armed = 1'b0;
                if (ctrl_q.f.over) ctrl_d.f.blank = 1'b1;
            end
            if (ctrl_q.f.blank && resume_i) ctrl_d.f.blank = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    scan_timer #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_CLKS (DIGIT_CLKS),
        .FIRST_EXTRA(FIRST_EXTRA),
        .STROBE_OFS (STROBE_OFS),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .run_i    (!ctrl_q.f.blank),
        .idx_o    (idx),
        .centre_o (centre)
    );

    digit_mux #(
        .NUM_DIGITS(NUM_DIGITS),
        .IDX_W     (IDX_W)
    ) u_mux (
        .data_i (ctrl_q.data),
        .idx_i  (idx),
        .blank_i(ctrl_q.f.blank),
        .zero_i (ctrl_q.f.over),
        .digit_o(digit_o),
        .bcd_o  (bcd_o)
    );

    strobe_gen u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .strobe_n_o(strobe_n_o)
    );

    // R1
    select_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_o));

    // R4
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_o == '0) |-> (bcd_o == '0));

    // R8
    over_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.f.over |-> (bcd_o == '0));

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.f.blank |-> (digit_o == '0));

    // R6
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.f.armed) |-> $past(digit_o[0]));
endmodule

// File: tb/sim_bcd_scanner.sv
module sim_bcd_scanner;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] result;
    logic        over, newr, resume;
    logic [4:0]  digit;
    logic [3:0]  bcd;
    logic        strobe_n;

    always #10 clk = ~clk;

    bcd_scanner u0 (
        .clk(clk), .rst_n(rst_n), .result_i(result), .over_i(over),
        .new_result_i(newr), .resume_i(resume),
        .digit_o(digit), .bcd_o(bcd), .strobe_n_o(strobe_n)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    int          m_idx, m_cnt;
    bit          m_armed, m_blank, m_over;
    logic [19:0] m_data;
    int          exp_str, obs_str;

    function automatic int len_of(int i); return (i == 4) ? 201 : 200; endfunction
    function automatic int mid_of(int i); return (i == 4) ? 101 : 100; endfunction
    function automatic logic [4:0] exp_digit();
        return m_blank ? 5'b0 : (5'b1 << m_idx);
    endfunction
    function automatic logic [3:0] exp_bcd();
        return (m_blank || m_over) ? 4'h0 : m_data[m_idx*4 +: 4];
    endfunction
    function automatic bit exp_strobe();
        return m_armed && !m_blank && (m_cnt == mid_of(m_idx));
    endfunction
    function automatic logic [19:0] rand_result();
        logic [19:0] r;
        for (int k = 0; k < 5; k++) r[k*4 +: 4] = 4'($urandom_range(0, 9));
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx <= 4; m_cnt <= 0; m_armed <= 0; m_blank <= 0; m_over <= 0; m_data <= '0;
        end else if (newr) begin
            m_data <= result; m_over <= over; m_armed <= 1; m_blank <= 0;
            m_idx <= 4; m_cnt <= 0;
        end else if (m_blank) begin
            if (resume) begin m_blank <= 0; m_idx <= 4; m_cnt <= 0; end
        end else begin
            if (m_idx == 0 && m_cnt == mid_of(0)) begin
                m_armed <= 0;
                if (m_over) m_blank <= 1;
            end
            if (m_cnt == len_of(m_idx) - 1) begin
                m_cnt <= 0;
                m_idx <= (m_idx == 0) ? 4 : m_idx - 1;
            end else m_cnt <= m_cnt + 1;
        end
    end

    // per-cycle comparison: selects and bus at +5, strobe at +15
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk(m_blank ? "R9" : "R1", digit, exp_digit());
            chk(m_over ? "R8" : ((exp_digit() == 0) ? "R4" : "R3"), bcd, exp_bcd());
            chk("R5", strobe_n, 1'b1);
        end
        #10;
        if (rst_n && !done) begin
            chk("R5", strobe_n, !exp_strobe());
            if (exp_strobe()) exp_str++;
            if (!strobe_n) obs_str++;
        end
    end

    task automatic tick(int n); repeat (n) @(posedge clk); endtask

    task automatic load(logic [19:0] r, bit o);
        @(posedge clk); #2;
        result = r; over = o; newr = 1'b1;
        @(posedge clk); #2;
        newr = 1'b0;
        chk("R6", obs_str, exp_str);
        obs_str = 0; exp_str = 0;
    endtask

    task automatic pulse_resume();
        @(posedge clk); #2 resume = 1'b1;
        @(posedge clk); #2 resume = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w4, w3, s1, s2;
        void'($urandom(32'd2024));
        rst_n = 0; newr = 0; resume = 0; over = 0; result = '0;
        #35;
        chk("R11", digit, 5'b10000);
        chk("R11", bcd, 4'h0);
        chk("R11", strobe_n, 1'b1);
        @(posedge clk); @(posedge clk); #2 rst_n = 1;

        // R11: idle scan, no strobes
        tick(1100);
        chk("R11", obs_str, 0);

        // R2 / R5: widths and strobe offsets
        load(20'h12345, 0);
        w4 = 0; w3 = 0; s1 = -1; s2 = -1;
        for (int c = 0; c < 402; c++) begin
            #3;
            if (digit[4]) w4++;
            if (digit[3]) w3++;
            #10;
            if (!strobe_n) begin if (s1 < 0) s1 = c; else if (s2 < 0) s2 = c; end
            #7;
        end
        chk("R2", w4, 201);
        chk("R2", w3, 200);
        chk("R5", s1, 101);
        chk("R5", s2, 301);
        tick(1700);
        chk("R6", obs_str, 5);

        // R10: resume while scanning does nothing
        load(20'h90817, 0);
        tick(150);
        pulse_resume();
        repeat (49) @(posedge clk);
        #5;
        chk("R10", digit, 5'b01000);
        chk("R10", bcd, 4'h0);

        // R7: mid-scan restart
        tick(400);
        load(20'h56789, 0);
        #3;
        chk("R7", digit, 5'b10000);
        chk("R7", bcd, 4'h5);
        tick(1500);

        // R9 / R8: overrange blanking and blink
        load(20'h43210, 1);
        repeat (901) @(posedge clk);
        #5;
        chk("R9", digit, 5'b00001);
        chk("R8", bcd, 4'h0);
        #10;
        chk("R9", strobe_n, 1'b0);
        @(posedge clk); #5;
        chk("R9", digit, 5'b00000);
        tick(300); #5;
        chk("R9", digit, 5'b00000);
        pulse_resume();
        #3;
        chk("R9", digit, 5'b10000);
        tick(1100);
        chk("R6", obs_str, 5);
        pulse_resume();
        tick(500);

        // random mix
        for (int it = 0; it < 25; it++) begin
            load(rand_result(), ($urandom_range(0, 3) == 0));
            for (int j = 0; j < 4; j++) begin
                tick($urandom_range(50, 700));
                if ($urandom_range(0, 1) == 1) pulse_resume();
            end
        end
        load(20'h00000, 0);
        tick(1100);
        chk("R6", obs_str, 5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule